// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two page-table entries from memory, one after the other. A virtual address is split into three fields: a 12-bit outer index in the top bits, a 10-bit inner index below it, and a 10-bit byte offset within a 1024-byte page. The walk starts from a table base address. The outer index is checked against a table length before any memory read is issued. The outer entry gives a pointer to an inner table. The inner entry gives the physical frame.

A requester offers one virtual address at a time, together with an access kind (read or write). The walker holds `reqReady` low until the walk finishes. It issues single-word reads on a simple memory port and waits any number of cycles for each reply. It ends every walk with a one-cycle response that carries either the final entry and physical address, or a fault with a cause code. The final entry comes back unchanged, so the requester can load it straight into a translation cache.

Top module: `pt_walker`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `reqReady` is 1, `rspValid` is 0 and `memReqValid` is 0.
- R2: The first read of a walk uses address `tableBase + 4*outer`, where `outer` is virtual address bits 31:20. `tableBase` is sampled when the request is accepted.
- R3: The second read uses address `{outerEntry[31:10], 10'b0} + 4*inner`, where `inner` is virtual address bits 19:10.
- R4: If `outer >= tableLen`, the walk ends with `rspFault`=1 and `rspCause`=1, and no memory read is issued. `outer = tableLen-1` is allowed.
- R5: If the outer entry has bit 0 (valid) clear, the walk ends with cause 2 after exactly one memory read.
- R6: If the inner entry has bit 0 clear, the walk ends with cause 2.
- R7: Entry bit 1 grants read and bit 2 grants write. If a valid inner entry lacks the right for the requested access (`reqWrite`=1 needs bit 2, `reqWrite`=0 needs bit 1), the walk ends with cause 3.
- R8: On success, `rspFault`=0, `rspCause`=0, `rspEntry` equals the inner entry, and `rspPaddr` = `{entry[31:10], vaddr[9:0]}`.
- R9: On any fault, `rspEntry` and `rspPaddr` are zero.
- R10: Only one walk runs at a time. `reqReady` is low from the cycle after acceptance until the cycle after the response. `rspValid` is high for exactly one cycle.
- R11: The walker waits any number of cycles for `memRspValid` after each read.
- R12: `memReqValid` is a single-cycle pulse, and no new read is issued while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A translation request is offered |
| reqReady | output | 1 | The walker is idle and will accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access kind: 1 for write, 0 for read |
| tableBase | input | 32 | Byte address of the outer table |
| tableLen | input | 13 | Number of legal outer entries |
| memReqValid | output | 1 | Memory read strobe |
| memReqAddr | output | 32 | Byte address of the word to read |
| memRspValid | input | 1 | Read data is present |
| memRspData | input | 32 | Read data |
| rspValid | output | 1 | Walk result, one-cycle pulse |
| rspFault | output | 1 | The walk ended in a page fault |
| rspCause | output | 2 | Fault cause: 0 none, 1 index beyond length, 2 invalid entry, 3 access denied |
| rspEntry | output | 32 | Final page-table entry on success |
| rspPaddr | output | 32 | Translated physical address on success |

## Verification
On every cycle, the assertions check the handshake shape: response and read strobes are single-cycle pulses, only one read is outstanding, `reqReady` drops after acceptance, and a response never overlaps a read. They also check that fault responses carry zero data, that the cause code agrees with the fault flag, and that a successful response's frame matches its entry. The bench scenarios are needed to show the parts that depend on memory contents: the two computed table addresses, the number of reads each outcome takes, the length bound at its edges, the permission decision for each access kind, offset pass-through, and tolerance of long memory latencies.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Walk sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE
  } walkState_e;

  // Fault cause codes reported on rspCause
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_RANGE   = 2'd1,
    CAUSE_INVALID = 2'd2,
    CAUSE_PERM    = 2'd3
  } faultCause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic        takeReq;    // latch request, base and access kind
    logic        takeOuter;  // latch inner-table pointer
    logic        takeInner;  // latch final entry
    logic        setFault;   // record a fault cause
    faultCause_e faultCode;
    logic        pickInner;  // address mux: inner-table read
  } walkStrobe_t;

  // Entry bit positions
  localparam int unsigned ENTRY_VALID_BIT = 0;
  localparam int unsigned ENTRY_READ_BIT  = 1;
  localparam int unsigned ENTRY_WRITE_BIT = 2;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        outOfRange,
  input  logic        entryValid,
  input  logic        accessOk,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid
);

  walkState_e state;
  walkState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.takeReq = 1'b1;
          if (outOfRange) begin
            strobe.setFault  = 1'b1;
            strobe.faultCode = CAUSE_RANGE;
            stateNext        = ST_DONE;
          end else begin
            stateNext = ST_RD_OUTER;
          end
        end
      end
      ST_RD_OUTER: stateNext = ST_WT_OUTER;
      ST_WT_OUTER: begin
        if (memRspValid) begin
          if (entryValid) begin
            strobe.takeOuter = 1'b1;
            stateNext        = ST_RD_INNER;
          end else begin
            strobe.setFault  = 1'b1;
            strobe.faultCode = CAUSE_INVALID;
            stateNext        = ST_DONE;
          end
        end
      end
      ST_RD_INNER: begin
        strobe.pickInner = 1'b1;
        stateNext        = ST_WT_INNER;
      end
      ST_WT_INNER: begin
        strobe.pickInner = 1'b1;
        if (memRspValid) begin
          stateNext = ST_DONE;
          if (!entryValid) begin
            strobe.setFault  = 1'b1;
            strobe.faultCode = CAUSE_INVALID;
          end else if (!accessOk) begin
            strobe.setFault  = 1'b1;
            strobe.faultCode = CAUSE_PERM;
          end else begin
            strobe.takeInner = 1'b1;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign rspValid    = (state == ST_DONE);

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 10,
  parameter int unsigned OUTER_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobe_t           strobe,
  input  logic [ADDR_W-1:0]     reqVaddr,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     tableBase,
  input  logic [OUTER_BITS:0]   tableLen,
  input  logic [ADDR_W-1:0]     memRspData,
  output logic                  outOfRange,
  output logic                  entryValid,
  output logic                  accessOk,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic                  rspFault,
  output logic [1:0]            rspCause,
  output logic [ADDR_W-1:0]     rspEntry,
  output logic [ADDR_W-1:0]     rspPaddr
);

  localparam int unsigned INNER_BITS = ADDR_W - PAGE_BITS - OUTER_BITS;
  localparam int unsigned PTR_W      = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] vaReg;
  logic              writeReg;
  logic [ADDR_W-1:0] baseReg;
  logic [PTR_W-1:0]  innerPtr;
  logic [ADDR_W-1:0] entryReg;
  faultCause_e       causeReg;

  logic [OUTER_BITS-1:0] outerIdxIn;
  logic [OUTER_BITS-1:0] outerIdx;
  logic [INNER_BITS-1:0] innerIdx;
  logic [ADDR_W-1:0]     outerAddr;
  logic [ADDR_W-1:0]     innerAddr;

  // Bound check on the incoming address, before any read
  assign outerIdxIn = reqVaddr[ADDR_W-1 -: OUTER_BITS];
  assign outOfRange = ({1'b0, outerIdxIn} >= tableLen);

  // Entry checks on the word coming back from memory
  assign entryValid = memRspData[ENTRY_VALID_BIT];
  assign accessOk   = writeReg ? memRspData[ENTRY_WRITE_BIT]
                               : memRspData[ENTRY_READ_BIT];

  // Table entry addresses: each entry is one 4-byte word
  assign outerIdx  = vaReg[ADDR_W-1 -: OUTER_BITS];
  assign innerIdx  = vaReg[PAGE_BITS +: INNER_BITS];
  assign outerAddr = baseReg + ADDR_W'({outerIdx, 2'b00});
  assign innerAddr = {innerPtr, {PAGE_BITS{1'b0}}} + ADDR_W'({innerIdx, 2'b00});
  assign memReqAddr = strobe.pickInner ? innerAddr : outerAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      writeReg <= 1'b0;
      baseReg  <= '0;
      innerPtr <= '0;
      entryReg <= '0;
      causeReg <= CAUSE_NONE;
    end else begin
      if (strobe.takeReq) begin
        vaReg    <= reqVaddr;
        writeReg <= reqWrite;
        baseReg  <= tableBase;
        entryReg <= '0;
      end
      if (strobe.takeOuter) innerPtr <= memRspData[ADDR_W-1:PAGE_BITS];
      if (strobe.takeInner) entryReg <= memRspData;
      if (strobe.setFault)     causeReg <= strobe.faultCode;
      else if (strobe.takeReq) causeReg <= CAUSE_NONE;
    end
  end

  assign rspFault = (causeReg != CAUSE_NONE);
  assign rspCause = causeReg;
  assign rspEntry = rspFault ? '0 : entryReg;
  assign rspPaddr = rspFault ? '0
                  : {entryReg[ADDR_W-1:PAGE_BITS], vaReg[PAGE_BITS-1:0]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 10,
  parameter int unsigned OUTER_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqVaddr,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   tableBase,
  input  logic [OUTER_BITS:0] tableLen,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [ADDR_W-1:0]   memRspData,
  output logic                rspValid,
  output logic                rspFault,
  output logic [1:0]          rspCause,
  output logic [ADDR_W-1:0]   rspEntry,
  output logic [ADDR_W-1:0]   rspPaddr
);

  walkStrobe_t strobe;
  logic        outOfRange;
  logic        entryValid;
  logic        accessOk;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .outOfRange  (outOfRange),
    .entryValid  (entryValid),
    .accessOk    (accessOk),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid)
  );

  pt_walker_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .OUTER_BITS (OUTER_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .tableBase  (tableBase),
    .tableLen   (tableLen),
    .memRspData (memRspData),
    .outOfRange (outOfRange),
    .entryValid (entryValid),
    .accessOk   (accessOk),
    .memReqAddr (memReqAddr),
    .rspFault   (rspFault),
    .rspCause   (rspCause),
    .rspEntry   (rspEntry),
    .rspPaddr   (rspPaddr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReqValid,
  input logic              rspValid,
  input logic              rspFault,
  input logic [1:0]        rspCause,
  input logic [ADDR_W-1:0] rspEntry,
  input logic [ADDR_W-1:0] rspPaddr
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (reqReady && !memReqValid && !rspValid));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  assert_read_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_read_in_walk_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (!reqReady && !rspValid));

  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspEntry == '0 && rspPaddr == '0));

  assert_cause_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault == (rspCause != 2'd0)));

  assert_frame_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |->
      (rspEntry[0] && rspPaddr[ADDR_W-1:PAGE_BITS] == rspEntry[ADDR_W-1:PAGE_BITS]));

endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .rspValid    (rspValid),
  .rspFault    (rspFault),
  .rspCause    (rspCause),
  .rspEntry    (rspEntry),
  .rspPaddr    (rspPaddr)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqVaddr;
  logic        reqWrite;
  logic [31:0] tableBase;
  logic [12:0] tableLen;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        rspValid;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic [31:0] rspEntry;
  logic [31:0] rspPaddr;

  always #2 clk = ~clk;  // 250 MHz

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .tableBase(tableBase),
    .tableLen(tableLen), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspFault(rspFault), .rspCause(rspCause), .rspEntry(rspEntry),
    .rspPaddr(rspPaddr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Memory model with a programmable latency
  logic [31:0] mem [0:4095];
  logic [31:0] addrLog [0:255];
  int          readCount = 0;
  int          curLat = 1;
  int          waitCnt = 0;
  bit          busy = 0;
  logic [31:0] pendAddr;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (busy) begin
      if (waitCnt <= 1) begin
        memRspValid <= 1'b1;
        memRspData  <= mem[pendAddr[13:2]];
        busy        <= 0;
      end else begin
        waitCnt <= waitCnt - 1;
      end
    end
    if (memReqValid) begin
      pendAddr <= memReqAddr;
      waitCnt  <= curLat;
      busy     <= 1;
      addrLog[readCount[7:0]] <= memReqAddr;
      readCount <= readCount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One walk: returns outcome and read bookkeeping
  task automatic doWalk(input logic [31:0] va, input logic wr, input int lat,
                        output logic [1:0] cause, output logic fault,
                        output logic [31:0] entry, output logic [31:0] paddr,
                        output int nReads, output int firstIdx);
    int guard;
    @(negedge clk);
    curLat   = lat;
    firstIdx = readCount;
    reqValid = 1'b1;
    reqVaddr = va;
    reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 ready low after accept", {31'd0, reqReady}, 32'd0);
    guard = 0;
    while (!rspValid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (!rspValid) check("R11 response arrives", 32'd0, 32'd1);
    cause  = rspCause;
    fault  = rspFault;
    entry  = rspEntry;
    paddr  = rspPaddr;
    nReads = readCount - firstIdx;
    @(negedge clk);
    check("R10 ready back after response", {31'd0, reqReady}, 32'd1);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  cause;
    logic [31:0] paddr;
    logic [31:0] entry;
    logic [7:0]  lat;
    logic [1:0]  reads;
    logic [31:0] a1;
    logic [31:0] a2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1523, 1'b0, 2'd0, 32'h0012_3523, 32'h0012_3407, 8'd1, 2'd2, 32'h0, 32'h1014},
    '{32'h0000_1BFF, 1'b0, 2'd0, 32'h00AB_C3FF, 32'h00AB_C003, 8'd3, 2'd2, 32'h0, 32'h1018},
    '{32'h0000_1800, 1'b1, 2'd3, 32'h0,         32'h0,         8'd2, 2'd2, 32'h0, 32'h1018},
    '{32'h0000_1C00, 1'b0, 2'd2, 32'h0,         32'h0,         8'd1, 2'd2, 32'h0, 32'h101C},
    '{32'h0020_0000, 1'b0, 2'd2, 32'h0,         32'h0,         8'd4, 2'd1, 32'h8, 32'h0},
    '{32'h0040_0000, 1'b0, 2'd1, 32'h0,         32'h0,         8'd1, 2'd0, 32'h0, 32'h0},
    '{32'h0010_002A, 1'b1, 2'd0, 32'h0040_002A, 32'h0040_0007, 8'd2, 2'd2, 32'h4, 32'h2000},
    '{32'h003F_FC00, 1'b0, 2'd0, 32'hFFFF_FC00, 32'hFFFF_FC07, 8'd5, 2'd2, 32'hC, 32'h1FFC},
    '{32'hFFF0_0000, 1'b1, 2'd1, 32'h0,         32'h0,         8'd1, 2'd0, 32'h0, 32'h0},
    '{32'h0000_2000, 1'b0, 2'd3, 32'h0,         32'h0,         8'd2, 2'd2, 32'h0, 32'h1020}
  };

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [1:0]  cause;
    logic        fault;
    logic [31:0] entry;
    logic [31:0] paddr;
    int          nReads;
    int          firstIdx;

    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[0]      = 32'h0000_1001;   // outer 0 -> table at 0x1000
    mem[1]      = 32'h0000_2001;   // outer 1 -> table at 0x2000
    mem[2]      = 32'h0000_0000;   // outer 2 invalid
    mem[3]      = 32'h0000_1001;   // outer 3 shares table at 0x1000
    mem[12'h405] = 32'h0012_3407;  // read+write
    mem[12'h406] = 32'h00AB_C003;  // read only
    mem[12'h407] = 32'h0000_0000;  // invalid
    mem[12'h408] = 32'h0055_5005;  // write only
    mem[12'h7FF] = 32'hFFFF_FC07;  // last inner slot
    mem[12'h800] = 32'h0040_0007;
    mem[12'hC00] = 32'h0000_2001;  // alternate outer table at 0x3000

    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqWrite = 1'b0;
    tableBase = 32'h0; tableLen = 13'd4;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {31'd0, reqReady}, 32'd1);
    check("R1 reset rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 reset memReqValid", {31'd0, memReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, reqReady}, 32'd1);

    // Vector table: covers R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
    for (int k = 0; k < NV; k++) begin
      doWalk(VECS[k].va, VECS[k].wr, int'(VECS[k].lat), cause, fault, entry, paddr, nReads, firstIdx);
      check("R4 R5 R6 R7 cause", {30'd0, cause}, {30'd0, VECS[k].cause});
      check("R9 fault flag", {31'd0, fault}, {31'd0, VECS[k].cause != 2'd0});
      check("R8 R9 entry", entry, VECS[k].entry);
      check("R8 R9 paddr", paddr, VECS[k].paddr);
      check("R4 R5 R12 read count", nReads, {30'd0, VECS[k].reads});
      if (VECS[k].reads >= 2'd1) check("R2 outer address", addrLog[firstIdx[7:0]], VECS[k].a1);
      if (VECS[k].reads == 2'd2) check("R3 inner address", addrLog[8'(firstIdx + 1)], VECS[k].a2);
    end

    // R11: long memory latency
    doWalk(32'h0000_1523, 1'b0, 40, cause, fault, entry, paddr, nReads, firstIdx);
    check("R11 long latency paddr", paddr, 32'h0012_3523);
    check("R11 long latency entry", entry, 32'h0012_3407);

    // R2: base sampled from tableBase
    tableBase = 32'h0000_3000;
    doWalk(32'h0000_002A, 1'b1, 2, cause, fault, entry, paddr, nReads, firstIdx);
    check("R2 new base outer address", addrLog[firstIdx[7:0]], 32'h0000_3000);
    check("R2 new base paddr", paddr, 32'h0040_002A);
    tableBase = 32'h0;

    // R4: largest index passes a full-size length, then reads an invalid slot
    tableLen = 13'h1000;
    doWalk(32'hFFF0_0000, 1'b0, 1, cause, fault, entry, paddr, nReads, firstIdx);
    check("R4 max index not bounded", {30'd0, cause}, 32'd2);
    check("R4 max index address", addrLog[firstIdx[7:0]], 32'h0000_3FFC);

    // R4: zero length rejects index 0 without a read
    tableLen = 13'd0;
    doWalk(32'h0000_1523, 1'b0, 1, cause, fault, entry, paddr, nReads, firstIdx);
    check("R4 zero length cause", {30'd0, cause}, 32'd1);
    check("R4 zero length reads", nReads, 32'd0);

    summary();
  end

endmodule